// File: doc/BRIEF.md
# Display Scan Address Generator

This block produces the memory address used on display-fetch cycles. A character-position counter is reloaded with a programmed start address at every horizontal sync. While display is enabled it then advances on character-clock enables. Each counter value is remapped for byte, word or doubleword addressing, and the result is presented on a registered address output together with a one-cycle load strobe.

The update rate can be slowed by two or by four. An internal phase count sets which character clocks issue a fetch and which advance the counter. At each horizontal sync this phase is preset from a pan bit, so a line can begin half-way through a fetch period.

The output is a plain strobe with no ready input. Display timing sets the pace and cannot be stalled, so there is no back-pressure. A consumer must accept the address in the cycle in which `scan_load` is high.

Top module: `scan_addr_gen`

## Requirements
- R1: While `rst_n` is low, and after reset until the first fetch, `scan_addr` is 0 and `scan_load` is 0.
- R2: A cycle with `hsync` high loads `start_addr` into the counter and presets the phase. The phase becomes 0 at divide-by-one, and `pan_preset` (0 or 1) otherwise. A character-clock enable in the same cycle is ignored.
- R3: With `addr_mode` = 2'b00 (byte), the address equals the counter value.
- R4: With `addr_mode` = 2'b01 (word), the address is the counter shifted left by one. Bit 0 is then replaced with counter bit 15. Code 2'b11 behaves as byte.
- R5: With `addr_mode` = 2'b10 (doubleword), the address is the counter shifted left by two. After the shift, bit 0 is replaced with counter bit 12 and bit 1 with counter bit 13.
- R6: A fetch raises `scan_load` for exactly one cycle, in the cycle after the enabling character clock, and `scan_addr` changes only at that point. It holds its value at all other times.
- R7: With `div_sel` = 2'b00 (or 2'b11), every enabled character clock fetches the current counter value and then adds one to the counter.
- R8: With `div_sel` = 2'b01, a character clock fetches when the phase is 0 and advances the counter when the phase is 1. The phase toggles on every enabled character clock.
- R9: With `div_sel` = 2'b10, the phase counts 0..3 on enabled character clocks. The block fetches at phase 0 and advances the counter at phase 3.
- R10: Character-clock enables while `disp_en` is low change neither the counter, the phase nor the outputs.
- R11: The counter wraps from 16'hFFFF to 16'h0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| char_ce | input | 1 | Character-clock enable |
| disp_en | input | 1 | Horizontal display enable |
| hsync | input | 1 | Line start: reload the counter and preset the phase |
| start_addr | input | 16 | Programmed start address |
| addr_mode | input | 2 | 00 byte, 01 word, 10 doubleword, 11 byte |
| div_sel | input | 2 | 00 every clock, 01 divide by two, 10 divide by four, 11 every clock |
| pan_preset | input | 1 | Phase value loaded at hsync when dividing |
| scan_addr | output | 16 | Registered fetch address |
| scan_load | output | 1 | One-cycle strobe marking a new `scan_addr` |

## Verification
Every result is due exactly one clock edge after the character-clock enable that causes it. The driver pushes the expected address at the moment it raises `char_ce`. The monitor looks at `scan_load` and `scan_addr` on the falling edge that follows each rising edge, so every queued item is matched in the first cycle it can appear. Idle checks on the falling edge confirm that the address holds and the strobe stays low between fetches. These checks cover disabled display, hsync collisions and the non-fetch phases.

// File: rtl/scan_addr_pkg.sv
package scan_addr_pkg;

  typedef enum logic [1:0] {
    AM_BYTE  = 2'b00,
    AM_WORD  = 2'b01,
    AM_DWORD = 2'b10,
    AM_RSVD  = 2'b11
  } addr_mode_e;

  typedef enum logic [1:0] {
    DV_ONE  = 2'b00,
    DV_TWO  = 2'b01,
    DV_FOUR = 2'b10,
    DV_RSVD = 2'b11
  } div_sel_e;

  function automatic logic [1:0] div_last(input div_sel_e d);
    case (d)
      DV_TWO:  div_last = 2'd1;
      DV_FOUR: div_last = 2'd3;
      default: div_last = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/scan_phase.sv
module scan_phase
  import scan_addr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     line_start,
  input  logic     tick,
  input  div_sel_e div_sel,
  input  logic     pan,
  output logic     fetch,
  output logic     step
);

  logic [1:0] phase;
  logic [1:0] last;

  always_comb begin
    last  = div_last(div_sel);
    fetch = (last == 2'd0) || (phase == 2'd0);
    step  = (last == 2'd0) || (phase == last);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= 2'd0;
    end else if (line_start) begin
      phase <= (last == 2'd0) ? 2'd0 : {1'b0, pan};
    end else if (tick) begin
      phase <= step ? 2'd0 : phase + 2'd1;
    end
  end

  a_r2_phase_preset: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && div_sel != DV_ONE && div_sel != DV_RSVD) |=> phase == {1'b0, $past(pan)});

  a_r10_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !line_start) |=> $stable(phase));

  a_r8_two_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_sel == DV_TWO && phase == 2'd0) |=> phase == 2'd1);

endmodule

// File: rtl/scan_counter.sv
module scan_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_start,
  input  logic          tick,
  input  logic          step,
  input  logic [CW-1:0] start,
  output logic [CW-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (line_start) begin
      cnt <= start;
    end else if (tick && step) begin
      cnt <= cnt + 1'b1;
    end
  end

  a_r2_reload: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> cnt == $past(start));

  a_r11_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_start) |=> (cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1));

  a_r10_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !line_start) |=> $stable(cnt));

endmodule

// File: rtl/scan_map.sv
module scan_map
  import scan_addr_pkg::*;
#(
  parameter int CW = 16
) (
  input  addr_mode_e    mode,
  input  logic [CW-1:0] cnt,
  output logic [CW-1:0] addr
);

  localparam int WORD_PAGE = CW - 1;
  localparam int DW_LO     = CW - 4;
  localparam int DW_HI     = CW - 3;

  logic [CW-1:0] shl1;
  logic [CW-1:0] shl2;

  always_comb begin
    shl1 = cnt << 1;
    shl2 = cnt << 2;
    case (mode)
      AM_WORD:  addr = {shl1[CW-1:1], cnt[WORD_PAGE]};
      AM_DWORD: addr = {shl2[CW-1:2], cnt[DW_HI], cnt[DW_LO]};
      default:  addr = cnt;
    endcase
  end

endmodule

// File: rtl/scan_addr_gen.sv
module scan_addr_gen
  import scan_addr_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          char_ce,
  input  logic          disp_en,
  input  logic          hsync,
  input  logic [CW-1:0] start_addr,
  input  logic [1:0]    addr_mode,
  input  logic [1:0]    div_sel,
  input  logic          pan_preset,
  output logic [CW-1:0] scan_addr,
  output logic          scan_load
);

  logic          tick;
  logic          fetch;
  logic          step;
  logic [CW-1:0] cnt;
  logic [CW-1:0] mapped;
  div_sel_e      dsel;
  addr_mode_e    amode;

  assign tick  = char_ce && disp_en && !hsync;
  assign dsel  = div_sel_e'(div_sel);
  assign amode = addr_mode_e'(addr_mode);

  scan_phase u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_start (hsync),
    .tick       (tick),
    .div_sel    (dsel),
    .pan        (pan_preset),
    .fetch      (fetch),
    .step       (step)
  );

  scan_counter #(.CW(CW)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_start (hsync),
    .tick       (tick),
    .step       (step),
    .start      (start_addr),
    .cnt        (cnt)
  );

  scan_map #(.CW(CW)) u_map (
    .mode (amode),
    .cnt  (cnt),
    .addr (mapped)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scan_addr <= '0;
      scan_load <= 1'b0;
    end else begin
      scan_load <= tick && fetch;
      if (tick && fetch) scan_addr <= mapped;
    end
  end

  a_r6_load_cause: assert property (@(posedge clk) disable iff (!rst_n)
    scan_load |-> $past(char_ce && disp_en && !hsync));

  a_r6_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_load |-> $stable(scan_addr));

  a_r8_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_load && (dsel == DV_TWO || dsel == DV_FOUR) && $stable(div_sel)) |=> !scan_load);

  a_r10_display_off: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_en |=> !scan_load);

endmodule

// File: tb/test_scan_addr_gen.sv
module test_scan_addr_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        char_ce = 1'b0;
  logic        disp_en = 1'b0;
  logic        hsync = 1'b0;
  logic [15:0] start_addr = '0;
  logic [1:0]  addr_mode = '0;
  logic [1:0]  div_sel = '0;
  logic        pan_preset = 1'b0;
  logic [15:0] scan_addr;
  logic        scan_load;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  int unsigned exp_q[$];
  string       tag_q[$];
  logic [15:0] m_cnt = '0;
  logic [1:0]  m_phase = '0;
  logic [15:0] last_exp = '0;

  always #5 clk = ~clk;

  scan_addr_gen i_scan_addr_gen (
    .clk(clk), .rst_n(rst_n), .char_ce(char_ce), .disp_en(disp_en),
    .hsync(hsync), .start_addr(start_addr), .addr_mode(addr_mode),
    .div_sel(div_sel), .pan_preset(pan_preset),
    .scan_addr(scan_addr), .scan_load(scan_load)
  );

  function automatic logic [15:0] map_ref(input logic [1:0] m, input logic [15:0] c);
    case (m)
      2'b01:   map_ref = {c[14:0], c[15]};
      2'b10:   map_ref = {c[13:0], c[13], c[12]};
      default: map_ref = c;
    endcase
  endfunction

  function automatic logic [1:0] last_ref(input logic [1:0] d);
    last_ref = (d == 2'b01) ? 2'd1 : (d == 2'b10) ? 2'd3 : 2'd0;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_tick(input string tag);
    logic [1:0] lst;
    if (!disp_en) return;
    lst = last_ref(div_sel);
    if (lst == 0 || m_phase == 0) begin
      exp_q.push_back(map_ref(addr_mode, m_cnt));
      tag_q.push_back(tag);
      last_exp = map_ref(addr_mode, m_cnt);
    end
    if (lst == 0 || m_phase == lst) begin
      m_cnt = m_cnt + 1;
      m_phase = 0;
    end else begin
      m_phase = m_phase + 1;
    end
  endtask

  task automatic ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      char_ce = 1'b1;
      model_tick(tag);
    end
    @(negedge clk);
    char_ce = 1'b0;
  endtask

  task automatic line(input logic [15:0] sa, input bit pan, input bit with_ce);
    @(negedge clk);
    start_addr = sa;
    pan_preset = pan;
    hsync = 1'b1;
    char_ce = with_ce;
    m_cnt = sa;
    m_phase = (last_ref(div_sel) == 0) ? 2'd0 : {1'b0, pan};
    @(negedge clk);
    hsync = 1'b0;
    char_ce = 1'b0;
  endtask

  task automatic idle_check(input string tag);
    @(negedge clk);
    @(negedge clk);
    check(scan_load == 1'b0, {tag, " load idle"}, scan_load, 0);
    check(scan_addr == last_exp, {tag, " addr hold"}, scan_addr, last_exp);
  endtask

  always @(negedge clk) begin
    if (rst_n && scan_load) begin
      if (exp_q.size() == 0) begin
        check(0, "R6 unexpected load", scan_addr, 0);
      end else begin
        int unsigned e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(scan_addr == e[15:0], t, scan_addr, e);
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      check(0, "watchdog", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(scan_addr == 0, "R1 addr in reset", scan_addr, 0);
    check(scan_load == 0, "R1 load in reset", scan_load, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(scan_addr == 0 && scan_load == 0, "R1 after reset", {scan_load, scan_addr}, 0);

    disp_en = 1'b1;
    addr_mode = 2'b00; div_sel = 2'b00;
    line(16'h1234, 1'b0, 1'b0);
    ticks(5, "R3 R7 byte linear");
    idle_check("R6");

    addr_mode = 2'b01;
    line(16'h8001, 1'b1, 1'b0);
    ticks(3, "R4 word map");
    line(16'h7FFF, 1'b0, 1'b0);
    ticks(3, "R4 word page bit");

    addr_mode = 2'b10;
    line(16'h2FFE, 1'b0, 1'b0);
    ticks(4, "R5 dword substitution");
    line(16'h1FFF, 1'b0, 1'b0);
    ticks(3, "R5 dword bit12 bit13");

    addr_mode = 2'b11;
    line(16'h00F0, 1'b0, 1'b0);
    ticks(2, "R4 reserved as byte");

    addr_mode = 2'b00; div_sel = 2'b01;
    line(16'h0100, 1'b0, 1'b0);
    ticks(7, "R8 div2 pan0");
    idle_check("R8");
    line(16'h0200, 1'b1, 1'b0);
    ticks(7, "R8 R2 div2 pan1");

    div_sel = 2'b10;
    line(16'h0300, 1'b0, 1'b0);
    ticks(10, "R9 div4 pan0");
    line(16'h0400, 1'b1, 1'b0);
    ticks(10, "R9 R2 div4 pan1");

    div_sel = 2'b00;
    line(16'h0500, 1'b0, 1'b0);
    ticks(2, "R10 before off");
    disp_en = 1'b0;
    ticks(4, "R10 display off");
    idle_check("R10");
    disp_en = 1'b1;
    ticks(2, "R10 resume");

    addr_mode = 2'b01;
    ticks(2, "R2 pre collision");
    line(16'h0600, 1'b0, 1'b1);
    idle_check("R2 collision");
    ticks(2, "R2 after collision");

    addr_mode = 2'b00;
    line(16'hFFFE, 1'b0, 1'b0);
    ticks(4, "R11 wrap");
    idle_check("R11");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R6 missing loads", exp_q.size(), 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule